// File: doc/BRIEF.md
# Frame-Synchronized Serial DAC Word Loader

This block takes converter words from a DSP transceiver over three wires: a bit clock, a frame strobe and a data line. All three are sampled by the system clock. Every serial frame is 16 bits long and arrives most significant bit first. The block keeps only the leading bits of each frame. When the frame strobe falls, it moves those bits into a parallel holding register that drives a DAC.

The held word is presented in two forms. The first is the form in which it was received. The second is an unsigned offset-binary code for the converter.

One parameter sets the width of the kept field:
- 12 bits for the line-path converter, which receives two's-complement codes.
- 7 bits for the timing-recovery converter, which receives codes that are already offset binary.

If the strobe falls before the whole kept field has arrived, the word is dropped and an error pulse is raised.

Top module: `serial_dac_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released, the holding register shows the mid-scale code. For the line path this is received code `000000000000` and converter code `100000000000`. For the timing-recovery variant both forms are `1000000`. Both `load_vld` and `frame_err` are low.
- R2: Bits are taken on rising edges of `ser_clk` after the rising edge of `ser_sync`, most significant bit first. The first KEEP_BITS bits of the frame become the loaded word, with the first bit in the MSB position.
- R3: Frame bits after the first KEEP_BITS bits are ignored: 4 trailing bits on the line path, 9 on the timing-recovery variant. Two frames that differ only in those bits load the same value.
- R4: The holding register changes only on a falling edge of `ser_sync`. A complete frame with the strobe still high leaves the outputs unchanged.
- R5: A rising edge of `ser_sync` restarts the bit count at zero, wherever it occurs. Bit-clock pulses while no frame is open do not affect the loaded word.
- R6: If `ser_sync` falls before KEEP_BITS bits have been captured, the holding register keeps its value, `load_vld` stays low, and `frame_err` is high for exactly one cycle.
- R7: Each accepted frame raises `load_vld` for exactly one system-clock cycle. This happens in the same cycle in which the new value first appears on the outputs.
- R8: On the line path the converter code is the received two's-complement code with its MSB inverted. So `011111111111` maps to `111111111111`, `000000000000` to `100000000000`, `111111111111` to `011111111111`, and `100000000000` to `000000000000`.
- R9: On the timing-recovery variant the received code is passed to the converter output unchanged. `1111111` is full scale, `1000000` is mid-scale and `0000000` is the minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_sync | input | 1 | Frame strobe; its rise opens a frame and its fall loads the word |
| ser_data | input | 1 | Serial data, MSB first |
| hold_code | output | KEEP_BITS | Held word in the received code form |
| dac_code | output | KEEP_BITS | Held word as an offset-binary converter code |
| load_vld | output | 1 | One-cycle pulse when a new word is loaded |
| frame_err | output | 1 | One-cycle pulse when a short frame is dropped |

## Verification
Four properties are checked on every cycle:
- the holding register is at mid-scale after reset;
- the held word moves only in a cycle with `load_vld`;
- `load_vld` never lasts more than one cycle;
- an error pulse never coincides with a load and never disturbs the held word.

Some behaviour can only be shown by the directed scenarios. These cover which bits end up in the word, that trailing bits and stray bit clocks outside a frame are ignored, that a full frame does not load until the strobe falls, the four named code mappings, and the split case where an 8-bit frame loads the 7-bit variant while it is an error for the 12-bit one.

// File: rtl/sdl_pkg.sv
// Shared definitions for the serial DAC word loader.
// Assumes: nothing beyond IEEE 1800-2017.
package sdl_pkg;
    // Code form in which the serial word arrives
    typedef enum logic {
        CODE_TWOS   = 1'b0,
        CODE_OFFSET = 1'b1
    } code_fmt_e;

    localparam int SDL_FRAME_BITS = 16;
    localparam int SDL_SYNC_STAGES = 2;
endpackage

// File: rtl/sdl_sync.sv
// Multi-bit level synchronizer for the serial wires.
// Assumes: each bit is quasi-static relative to clk (several clk periods per level),
// so per-bit synchronization keeps data aligned with the bit clock.
module sdl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (STAGES <= 1) begin : g_single
            logic [W-1:0] stg_q;
            // Single sampling stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= din;
            end
            assign dout = stg_q;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] stg_q;
            // Shift the sampled levels through the stage chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[STAGES-2:0], din};
            end
            assign dout = stg_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sdl_capture.sv
// Frame bit counter and payload shift register.
// Assumes: a frame opens on sync_rise; bits arrive as bit_rise strobes with
// bit_data valid in the same cycle. Only the first KEEP_BITS bits are shifted in,
// and the counter saturates at FRAME_BITS.
module sdl_capture #(
    parameter int FRAME_BITS = 16,
    parameter int KEEP_BITS  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_rise,
    input  logic                 sync_fall,
    input  logic                 bit_rise,
    input  logic                 bit_data,
    output logic [KEEP_BITS-1:0] word,
    output logic                 ready
);
    localparam int              CNT_W  = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] KEEP_C  = CNT_W'(KEEP_BITS);

    logic [CNT_W-1:0]     cnt_q;
    logic [KEEP_BITS-1:0] shreg_q;
    logic                 open_q;

    // Track the frame window and count and shift the captured bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= FRAME_C;
            shreg_q <= '0;
            open_q  <= 1'b0;
        end else if (sync_rise) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            open_q  <= 1'b1;
        end else begin
            if (sync_fall) open_q <= 1'b0;
            if (bit_rise && open_q && cnt_q < FRAME_C) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (cnt_q < KEEP_C) shreg_q <= {shreg_q[KEEP_BITS-2:0], bit_data};
            end
        end
    end

    assign word  = shreg_q;
    assign ready = open_q && (cnt_q >= KEEP_C);
endmodule

// File: rtl/sdl_hold.sv
// DAC holding register with load/error pulses and the offset-binary view.
// Assumes: load_req is a one-cycle strobe at the frame strobe's fall; ready
// reflects the capture state from before that edge.
module sdl_hold
    import sdl_pkg::*;
#(
    parameter int        KEEP_BITS  = 12,
    parameter code_fmt_e RAW_FORMAT = CODE_TWOS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_req,
    input  logic                 ready,
    input  logic [KEEP_BITS-1:0] word,
    output logic [KEEP_BITS-1:0] hold_code,
    output logic [KEEP_BITS-1:0] dac_code,
    output logic                 load_vld,
    output logic                 frame_err
);
    localparam logic [KEEP_BITS-1:0] MID_OFS = {1'b1, {(KEEP_BITS-1){1'b0}}};
    localparam logic [KEEP_BITS-1:0] MID_RAW = (RAW_FORMAT == CODE_OFFSET) ? MID_OFS : '0;

    logic [KEEP_BITS-1:0] hold_q;
    logic                 vld_q;
    logic                 err_q;

    // Accept a complete word or flag a short frame at the strobe's fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= MID_RAW;
            vld_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            err_q <= 1'b0;
            if (load_req) begin
                if (ready) begin
                    hold_q <= word;
                    vld_q  <= 1'b1;
                end else begin
                    err_q  <= 1'b1;
                end
            end
        end
    end

    generate
        if (RAW_FORMAT == CODE_TWOS) begin : g_twos
            assign dac_code = {~hold_q[KEEP_BITS-1], hold_q[KEEP_BITS-2:0]};
        end else begin : g_ofs
            assign dac_code = hold_q;
        end
    endgenerate

    assign hold_code = hold_q;
    assign load_vld  = vld_q;
    assign frame_err = err_q;
endmodule

// File: rtl/serial_dac_loader.sv
// Top level: synchronizes the three serial wires, finds the strobe and clock
// edges, captures the leading field of each frame and loads it at the strobe's fall.
// Assumes: ser_clk and ser_sync stay at each level for more than SYNC_STAGES
// system clocks, and ser_data is stable around each ser_clk rise.
module serial_dac_loader
    import sdl_pkg::*;
#(
    parameter int        FRAME_BITS  = SDL_FRAME_BITS,
    parameter int        KEEP_BITS   = 12,
    parameter int        SYNC_STAGES = SDL_SYNC_STAGES,
    parameter code_fmt_e RAW_FORMAT  = CODE_TWOS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_sync,
    input  logic                 ser_data,
    output logic [KEEP_BITS-1:0] hold_code,
    output logic [KEEP_BITS-1:0] dac_code,
    output logic                 load_vld,
    output logic                 frame_err
);
    localparam int IDX_CLK  = 0;
    localparam int IDX_SYNC = 1;
    localparam int IDX_DATA = 2;

    logic [2:0]           lvl;
    logic [1:0]           prev_q;
    logic                 bit_rise, sync_rise, sync_fall;
    logic [KEEP_BITS-1:0] word;
    logic                 ready;

    sdl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_data, ser_sync, ser_clk}),
        .dout (lvl)
    );

    // Delay the clock and strobe levels by one cycle for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= {lvl[IDX_SYNC], lvl[IDX_CLK]};
    end

    assign bit_rise  =  lvl[IDX_CLK]  & ~prev_q[0];
    assign sync_rise =  lvl[IDX_SYNC] & ~prev_q[1];
    assign sync_fall = ~lvl[IDX_SYNC] &  prev_q[1];

    sdl_capture #(.FRAME_BITS(FRAME_BITS), .KEEP_BITS(KEEP_BITS)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_rise(sync_rise),
        .sync_fall(sync_fall),
        .bit_rise (bit_rise),
        .bit_data (lvl[IDX_DATA]),
        .word     (word),
        .ready    (ready)
    );

    sdl_hold #(.KEEP_BITS(KEEP_BITS), .RAW_FORMAT(RAW_FORMAT)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (sync_fall),
        .ready    (ready),
        .word     (word),
        .hold_code(hold_code),
        .dac_code (dac_code),
        .load_vld (load_vld),
        .frame_err(frame_err)
    );
endmodule

// File: rtl/sdl_checker.sv
// Protocol checks on the loader's outputs; bound into every serial_dac_loader.
// Assumes: rst_n is held low for at least one clock edge at start-up.
module sdl_checker
    import sdl_pkg::*;
#(
    parameter int        KEEP_BITS  = 12,
    parameter code_fmt_e RAW_FORMAT = CODE_TWOS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [KEEP_BITS-1:0] hold_code,
    input logic                 load_vld,
    input logic                 frame_err
);
    localparam logic [KEEP_BITS-1:0] MID_RAW =
        (RAW_FORMAT == CODE_OFFSET) ? {1'b1, {(KEEP_BITS-1){1'b0}}} : '0;

    // R1
    reset_mid_chk: assert property (@(posedge clk)
        !rst_n |=> (hold_code == MID_RAW && !load_vld && !frame_err));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_vld |-> $stable(hold_code));

    // R7
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_vld |=> !load_vld);

    // R6
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (!load_vld && $stable(hold_code)));

    // R6
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);
endmodule

bind serial_dac_loader sdl_checker #(
    .KEEP_BITS (KEEP_BITS),
    .RAW_FORMAT(RAW_FORMAT)
) u_sdl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_code(hold_code),
    .load_vld (load_vld),
    .frame_err(frame_err)
);

// File: tb/serial_dac_loader_bench.sv
// Directed bench: a line-path loader (12 bits, two's complement) and a
// timing-recovery loader (7 bits, offset binary) share the same serial wires.
module serial_dac_loader_bench;
    import sdl_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_sync = 1'b0;
    logic        ser_data = 1'b0;
    logic [11:0] ln_hold, ln_dac;
    logic [6:0]  tr_hold, tr_dac;
    logic        ln_vld, ln_err, tr_vld, tr_err;

    int checks = 0;
    int errors = 0;
    int ln_vld_cyc = 0, ln_err_cyc = 0, tr_vld_cyc = 0, tr_err_cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_dac_loader #(.KEEP_BITS(12), .RAW_FORMAT(CODE_TWOS)) u_serial_dac_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_data(ser_data),
        .hold_code(ln_hold), .dac_code(ln_dac), .load_vld(ln_vld), .frame_err(ln_err)
    );

    serial_dac_loader #(.KEEP_BITS(7), .RAW_FORMAT(CODE_OFFSET)) u_serial_dac_loader_tr (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_data(ser_data),
        .hold_code(tr_hold), .dac_code(tr_dac), .load_vld(tr_vld), .frame_err(tr_err)
    );

    // Count the cycles in which each pulse output is high
    always @(negedge clk) begin
        if (rst_n) begin
            if (ln_vld) ln_vld_cyc++;
            if (ln_err) ln_err_cyc++;
            if (tr_vld) tr_vld_cyc++;
            if (tr_err) tr_err_cyc++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_data = b;
        ser_clk  = 1'b0;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Open a frame, send nbits MSB first, wait, close it, let the result settle
    task automatic send_frame(input logic [15:0] w, input int nbits, input int gap);
        @(negedge clk);
        ser_sync = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) send_bit(w[15-i]);
        repeat (gap) @(negedge clk);
        ser_sync = 1'b0;
        repeat (12) @(negedge clk);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Check both loaders against a frame word; the 12-bit and 7-bit leading fields
    task automatic expect_both(input string req, input logic [15:0] w);
        logic [11:0] ln;
        logic [6:0]  tr;
        ln = w[15:4];
        tr = w[15:9];
        chk({req, " line received"}, int'(ln_hold), int'(ln));
        chk({req, " line converter"}, int'(ln_dac), int'({~ln[11], ln[10:0]}));
        chk({req, " timing received"}, int'(tr_hold), int'(tr));
        chk({req, " timing converter"}, int'(tr_dac), int'(tr));
    endtask

    task automatic t_reset();
        // R1
        chk("R1 line received", int'(ln_hold), 'h000);
        chk("R1 line converter", int'(ln_dac), 'h800);
        chk("R1 timing received", int'(tr_hold), 'h40);
        chk("R1 timing converter", int'(tr_dac), 'h40);
        chk("R1 pulses low", int'({ln_vld, ln_err, tr_vld, tr_err}), 0);
    endtask

    task automatic t_basic();
        int v0 = ln_vld_cyc, t0 = tr_vld_cyc;
        // R2 R7 R8 R9
        send_frame(16'h5A3C, 16, 2);
        expect_both("R2", 16'h5A3C);
        chk("R7 line one pulse cycle", ln_vld_cyc - v0, 1);
        chk("R7 timing one pulse cycle", tr_vld_cyc - t0, 1);
    endtask

    task automatic t_trailing();
        // R3: trailing bits differ from the previous frame's, kept field too
        send_frame(16'h1230, 16, 2);
        expect_both("R3 first", 16'h1230);
        send_frame(16'h123F, 16, 2);
        chk("R3 line trailing ignored", int'(ln_hold), 'h123);
        chk("R3 timing trailing ignored", int'(tr_hold), 'h09);
    endtask

    task automatic t_hold_until_fall();
        int v0 = ln_vld_cyc;
        logic [15:0] w = 16'hFEDC;
        // R4: all bits in, strobe still high
        @(negedge clk);
        ser_sync = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 16; i++) send_bit(w[15-i]);
        repeat (20) @(negedge clk);
        chk("R4 line unchanged before fall", int'(ln_hold), 'h123);
        chk("R4 no pulse before fall", ln_vld_cyc - v0, 0);
        ser_sync = 1'b0;
        repeat (12) @(negedge clk);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        expect_both("R4 after fall", w);
    endtask

    task automatic t_pre_sync_bits();
        // R5: stray bit clocks with data high outside a frame
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 stray bits ignored", int'(ln_hold), 'hFED);
        send_frame(16'h8000, 16, 2);
        expect_both("R5", 16'h8000);
    endtask

    task automatic t_short();
        int v0 = ln_vld_cyc, e0 = ln_err_cyc, tv0 = tr_vld_cyc, te0 = tr_err_cyc;
        // R6: five bits only, both variants drop it
        send_frame(16'h0000, 5, 2);
        chk("R6 line error pulse", ln_err_cyc - e0, 1);
        chk("R6 timing error pulse", tr_err_cyc - te0, 1);
        chk("R6 line no load", ln_vld_cyc - v0, 0);
        chk("R6 line held", int'(ln_hold), 'h800);
        chk("R6 timing held", int'(tr_hold), 'h40);
        // R6: eight bits, error for 12-bit, enough for 7-bit
        send_frame(16'h7FFF, 8, 2);
        chk("R6 line error on 8 bits", ln_err_cyc - e0, 2);
        chk("R6 line held after 8 bits", int'(ln_hold), 'h800);
        chk("R6 timing loads on 8 bits", int'(tr_hold), 'h3F);
        chk("R6 timing valid on 8 bits", tr_vld_cyc - tv0, 1);
    endtask

    task automatic t_codes();
        logic [15:0] w;
        // R8 R9: named code points
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: w = 16'h7FF0;
                1: w = 16'h0000;
                2: w = 16'hFFF0;
                default: w = 16'h8000;
            endcase
            send_frame(w, 16, 2);
            expect_both("R8", w);
        end
    endtask

    task automatic t_reset_again();
        // R1: reset after activity
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_basic();
        t_trailing();
        t_hold_until_fall();
        t_pre_sync_bits();
        t_short();
        t_codes();
        t_reset_again();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule